// File: doc/BRIEF.md
# Restore-Tracking Save Optimizer

This block remembers the context in which processor state was last restored. It also tracks which state components have been written since that restore. When a later save asks about that state, the block reports which components the save sequencer may leave out, because the memory image from the restore still holds their current contents.

The remembered context is a tuple of four fields: privilege level, a guest-mode flag, the linear address of the save area, and the compaction mask. A restore event records the tuple and clears a per-component modified bitmap. Execution units pulse a per-component modify strobe whenever they write a component.

On a save query, the block forms the current compaction mask as the requested-feature mask with bit 63 forced to 1. It then compares the whole current tuple against the stored tuple. One cycle after the query, it presents an optimization flag and a registered skip vector.

Top module: `save_opt_top`

## Requirements
- R1: After reset, skipValid, skipVec and optEnable are 0, and no tuple is held. A query made before the first restore returns optEnable = 0 and skipVec = 0.
- R2: skipValid is 1 in exactly the cycle after a cycle with saveQuery = 1, and 0 in every other cycle.
- R3: The compaction mask used in the compare is reqMask with bit 63 set to 1. A restore whose stored mask has bit 63 = 0 can therefore never be matched.
- R4: optEnable is 1 only when a restore has been recorded and all four fields match exactly: privilege, guest flag, address, and compaction mask. A difference in any one field gives 0.
- R5: skipVec bit i is 1 only when all four of these hold: optEnable is 1, component i is unmodified since the last restore, reqMask bit i is 1, and inUse bit i is 1. Component i is mask bit i.
- R6: A restore reloads the tuple and clears every modified bit in the same cycle.
- R7: modifyStrobe bit i sets modified bit i. When it arrives in the same cycle as a restore, the bit ends up set.
- R8: A query evaluates the state held before any restore or strobe that arrives in the same cycle.
- R9: skipVec and optEnable hold their values until the next query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| restoreValid | input | 1 | Restore event: record the tuple |
| restorePriv | input | PRIV_W | Privilege level at restore |
| restoreGuest | input | 1 | Guest-mode flag at restore |
| restoreAddr | input | ADDR_W | Save-area linear address at restore |
| restoreMask | input | MASK_W | Compaction mask at restore |
| modifyStrobe | input | NUM_COMP | Per-component write notification |
| saveQuery | input | 1 | Save query strobe |
| curPriv | input | PRIV_W | Privilege level at save |
| curGuest | input | 1 | Guest-mode flag at save |
| curAddr | input | ADDR_W | Save-area linear address at save |
| reqMask | input | MASK_W | Requested-feature mask at save |
| inUse | input | NUM_COMP | Components currently in use |
| skipValid | output | 1 | Result valid, one cycle after the query |
| skipVec | output | NUM_COMP | Components the save may skip |
| optEnable | output | 1 | Tuple matched at the last query |

## Verification
The bench changes one tuple field at a time against an otherwise matching tuple. A compare that ignored the address, the guest flag or the forced bit 63 would still report a match in that case.

It sends a modify strobe in the same cycle as a restore. A design that let the clear win would report a freshly written component as skippable.

It sends a query in the same cycle as a restore. A design that compared against the incoming tuple would answer with the wrong context.

It also checks that components which are masked out or not in use are never skipped. Finally, it checks that the result holds between queries.

// File: rtl/save_opt_pkg.sv
package save_opt_pkg;
  typedef struct packed {
    logic loadTuple;
    logic clearMod;
    logic captureSkip;
  } opt_ctrl_t;
endpackage

// File: rtl/save_opt_ctrl.sv
module save_opt_ctrl
  import save_opt_pkg::*;
(
  input  logic      restoreValid,
  input  logic      saveQuery,
  output opt_ctrl_t ctrl
);
  always_comb begin
    ctrl.loadTuple   = restoreValid;
    ctrl.clearMod    = restoreValid;
    ctrl.captureSkip = saveQuery;
  end
endmodule

// File: rtl/save_opt_dp.sv
module save_opt_dp
  import save_opt_pkg::*;
#(
  parameter int NUM_COMP = 8,
  parameter int MASK_W   = 64,
  parameter int ADDR_W   = 48,
  parameter int PRIV_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  opt_ctrl_t           ctrl,
  input  logic [PRIV_W-1:0]   restorePriv,
  input  logic                restoreGuest,
  input  logic [ADDR_W-1:0]   restoreAddr,
  input  logic [MASK_W-1:0]   restoreMask,
  input  logic [NUM_COMP-1:0] modifyStrobe,
  input  logic [PRIV_W-1:0]   curPriv,
  input  logic                curGuest,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic [MASK_W-1:0]   reqMask,
  input  logic [NUM_COMP-1:0] inUse,
  output logic                skipValid,
  output logic [NUM_COMP-1:0] skipVec,
  output logic                optEnable
);
  localparam int FORCED_BIT = MASK_W - 1;
  localparam logic [MASK_W-1:0] FORCE_MASK = MASK_W'(1) << FORCED_BIT;

  logic [PRIV_W-1:0]   storedPriv;
  logic                storedGuest;
  logic [ADDR_W-1:0]   storedAddr;
  logic [MASK_W-1:0]   storedMask;
  logic                tupleValid;
  logic [NUM_COMP-1:0] modified;
  logic [MASK_W-1:0]   compMask;
  logic                optNow;
  logic [NUM_COMP-1:0] skipNow;

  assign compMask = reqMask | FORCE_MASK;
  assign optNow   = tupleValid && (curPriv == storedPriv) && (curGuest == storedGuest)
                    && (curAddr == storedAddr) && (compMask == storedMask);

  for (genvar i = 0; i < NUM_COMP; i++) begin : g_skip
    assign skipNow[i] = optNow & ~modified[i] & reqMask[i] & inUse[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedPriv  <= '0;
      storedGuest <= 1'b0;
      storedAddr  <= '0;
      storedMask  <= '0;
      tupleValid  <= 1'b0;
      modified    <= '0;
      skipVec     <= '0;
      optEnable   <= 1'b0;
      skipValid   <= 1'b0;
    end else begin
      if (ctrl.loadTuple) begin
        storedPriv  <= restorePriv;
        storedGuest <= restoreGuest;
        storedAddr  <= restoreAddr;
        storedMask  <= restoreMask;
        tupleValid  <= 1'b1;
      end
      modified <= (ctrl.clearMod ? '0 : modified) | modifyStrobe;
      if (ctrl.captureSkip) begin
        skipVec   <= skipNow;
        optEnable <= optNow;
      end
      skipValid <= ctrl.captureSkip;
    end
  end

  // R2
  valid_after_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.captureSkip |=> skipValid);
  // R2
  valid_only_after_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.captureSkip |=> !skipValid);
  // R5
  no_skip_without_opt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !optEnable |-> skipVec == '0);
  // R7
  strobe_sets_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|modifyStrobe) |=> ((modified & $past(modifyStrobe)) == $past(modifyStrobe)));
  // R6
  restore_clears_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearMod |=> ((modified & ~$past(modifyStrobe)) == '0));
  // R9
  hold_between_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.captureSkip |=> ($stable(skipVec) && $stable(optEnable)));
endmodule

// File: rtl/save_opt_top.sv
module save_opt_top
  import save_opt_pkg::*;
#(
  parameter int NUM_COMP = 8,
  parameter int MASK_W   = 64,
  parameter int ADDR_W   = 48,
  parameter int PRIV_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                restoreValid,
  input  logic [PRIV_W-1:0]   restorePriv,
  input  logic                restoreGuest,
  input  logic [ADDR_W-1:0]   restoreAddr,
  input  logic [MASK_W-1:0]   restoreMask,
  input  logic [NUM_COMP-1:0] modifyStrobe,
  input  logic                saveQuery,
  input  logic [PRIV_W-1:0]   curPriv,
  input  logic                curGuest,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic [MASK_W-1:0]   reqMask,
  input  logic [NUM_COMP-1:0] inUse,
  output logic                skipValid,
  output logic [NUM_COMP-1:0] skipVec,
  output logic                optEnable
);
  opt_ctrl_t ctrl;

  save_opt_ctrl u_ctrl (
    .restoreValid(restoreValid),
    .saveQuery(saveQuery),
    .ctrl(ctrl)
  );

  save_opt_dp #(.NUM_COMP(NUM_COMP), .MASK_W(MASK_W), .ADDR_W(ADDR_W), .PRIV_W(PRIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .restorePriv(restorePriv), .restoreGuest(restoreGuest),
    .restoreAddr(restoreAddr), .restoreMask(restoreMask),
    .modifyStrobe(modifyStrobe),
    .curPriv(curPriv), .curGuest(curGuest), .curAddr(curAddr),
    .reqMask(reqMask), .inUse(inUse),
    .skipValid(skipValid), .skipVec(skipVec), .optEnable(optEnable)
  );
endmodule

// File: tb/tb_save_opt_top.sv
module tb_save_opt_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam logic [63:0] B63 = 64'h8000_0000_0000_0000;

  logic clk = 0, rstN = 0;
  logic restoreValid = 0, restoreGuest = 0, saveQuery = 0, curGuest = 0;
  logic [1:0] restorePriv = 0, curPriv = 0;
  logic [47:0] restoreAddr = 0, curAddr = 0;
  logic [63:0] restoreMask = 0, reqMask = 0;
  logic [NC-1:0] modifyStrobe = 0, inUse = 0;
  logic skipValid, optEnable;
  logic [NC-1:0] skipVec;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  save_opt_top dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doRestore(input logic [1:0] p, input logic g, input logic [47:0] a,
                           input logic [63:0] m, input logic [NC-1:0] mod);
    restoreValid = 1; restorePriv = p; restoreGuest = g; restoreAddr = a; restoreMask = m;
    modifyStrobe = mod;
    @(negedge clk);
    restoreValid = 0; modifyStrobe = 0;
  endtask

  task automatic doModify(input logic [NC-1:0] mod);
    modifyStrobe = mod;
    @(negedge clk);
    modifyStrobe = 0;
  endtask

  task automatic saveCheck(input logic [1:0] p, input logic g, input logic [47:0] a,
                           input logic [63:0] r, input logic [NC-1:0] u,
                           input logic [NC-1:0] expSkip, input logic expOpt, input string tag);
    saveQuery = 1; curPriv = p; curGuest = g; curAddr = a; reqMask = r; inUse = u;
    @(negedge clk);
    saveQuery = 0;
    chk({tag, " R2 valid"}, 64'(skipValid), 64'd1);
    chk({tag, " opt"}, 64'(optEnable), 64'(expOpt));
    chk({tag, " skip"}, 64'(skipVec), 64'(expSkip));
    @(negedge clk);
    chk({tag, " R2 valid drop"}, 64'(skipValid), 64'd0);
  endtask

  task automatic testReset();
    chk("R1 reset valid", 64'(skipValid), 0);
    chk("R1 reset skip", 64'(skipVec), 0);
    chk("R1 reset opt", 64'(optEnable), 0);
    saveCheck(0, 0, 0, 64'hFF, 8'hFF, 8'h00, 0, "R1 no tuple");
  endtask

  task automatic testMatch();
    doRestore(2'd0, 1'b1, 48'h1000, B63 | 64'h0F, 8'h00);
    saveCheck(2'd0, 1'b1, 48'h1000, 64'h0F, 8'hFF, 8'h0F, 1, "R4 R5 full match");
    saveCheck(2'd0, 1'b1, 48'h1000, 64'h0F, 8'h05, 8'h05, 1, "R5 inUse filter");
  endtask

  task automatic testMismatch();
    saveCheck(2'd3, 1'b1, 48'h1000, 64'h0F, 8'hFF, 8'h00, 0, "R4 priv diff");
    saveCheck(2'd0, 1'b0, 48'h1000, 64'h0F, 8'hFF, 8'h00, 0, "R4 guest diff");
    saveCheck(2'd0, 1'b1, 48'h1040, 64'h0F, 8'hFF, 8'h00, 0, "R4 addr diff");
    saveCheck(2'd0, 1'b1, 48'h1000, 64'h07, 8'hFF, 8'h00, 0, "R3 mask diff");
    saveCheck(2'd0, 1'b1, 48'h1000, B63 | 64'h0F, 8'hFF, 8'h0F, 1, "R3 bit63 in req");
  endtask

  task automatic testNoBit63();
    doRestore(2'd1, 1'b0, 48'h2000, 64'h03, 8'h00);
    saveCheck(2'd1, 1'b0, 48'h2000, 64'h03, 8'hFF, 8'h00, 0, "R3 stored lacks bit63");
  endtask

  task automatic testModifyClear();
    doRestore(2'd0, 1'b0, 48'h3000, B63 | 64'h3C, 8'h00);
    doModify(8'h04);
    saveCheck(2'd0, 1'b0, 48'h3000, 64'h3C, 8'hFF, 8'h38, 1, "R7 modified kept");
    doRestore(2'd0, 1'b0, 48'h3000, B63 | 64'h3C, 8'h00);
    saveCheck(2'd0, 1'b0, 48'h3000, 64'h3C, 8'hFF, 8'h3C, 1, "R6 restore clears");
    doRestore(2'd0, 1'b0, 48'h3000, B63 | 64'h3C, 8'h10);
    saveCheck(2'd0, 1'b0, 48'h3000, 64'h3C, 8'hFF, 8'h2C, 1, "R7 strobe wins");
  endtask

  task automatic testSameCycle();
    doRestore(2'd2, 1'b0, 48'h4000, B63 | 64'h01, 8'h00);
    restoreValid = 1; restorePriv = 2'd2; restoreGuest = 0; restoreAddr = 48'h5000;
    restoreMask = B63 | 64'h01;
    saveQuery = 1; curPriv = 2'd2; curGuest = 0; curAddr = 48'h4000; reqMask = 64'h01; inUse = 8'h01;
    @(negedge clk);
    restoreValid = 0; saveQuery = 0;
    chk("R8 old tuple opt", 64'(optEnable), 1);
    chk("R8 old tuple skip", 64'(skipVec), 64'h01);
    @(negedge clk);
    saveCheck(2'd2, 1'b0, 48'h5000, 64'h01, 8'h01, 8'h01, 1, "R8 new tuple");
  endtask

  task automatic testHold();
    doRestore(2'd0, 1'b0, 48'h6000, B63 | 64'hF0, 8'h00);
    saveCheck(2'd0, 1'b0, 48'h6000, 64'hF0, 8'hFF, 8'hF0, 1, "R9 setup");
    doModify(8'hFF);
    curAddr = 48'h0; reqMask = 0;
    repeat (3) @(negedge clk);
    chk("R9 skip held", 64'(skipVec), 64'hF0);
    chk("R9 opt held", 64'(optEnable), 1);
    chk("R2 idle valid", 64'(skipValid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testMatch();
    testMismatch();
    testNoBit63();
    testModifyClear();
    testSameCycle();
    testHold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule